// File: doc/BRIEF.md
# Register Write Sequencer

The block runs short scripts of register updates without a processor. A host port fills a 256-entry step memory. A start request names the first step, and a dedicated trigger input starts at a fixed index set by a parameter. Each step updates one bit field of a 16-bit control register. The engine reads the register over a simple master bus, replaces the field of 1 to 8 bits at the given offset, and writes the result back. It then waits a delay set by an exponential code before it moves to the next step.

Delay code 15 marks the last step of a sequence. That step still performs its write, and the engine then goes idle and raises a one-cycle completion pulse. Delays are counted in clock cycles. Two parameters give the base cycle count and the unit cycle count.

Top module: `regseq_engine`

## Requirements
- R1: Each step is two 16-bit words. Word 0 (`cfg_word_i`=0) holds the width code in bits 15:13 and the register address in bits 12:0. Word 1 (`cfg_word_i`=1) holds the delay code in bits 15:12, the field LSB position in bits 11:8 and the data in bits 7:0.
- R2: Width code n updates a field of n+1 bits. Data bits at or above position n+1 are ignored.
- R3: The field starts at the LSB position (0 to 15). Field bits that would land above bit 15 are dropped.
- R4: Each step reads the target register and then writes the same address. Bits outside the field keep the value that was read. The request and address stay stable until the acknowledge.
- R5: The delay after a write is N cycles: N = BASE_CYC for code 0, and N = UNIT_CYC*(2^code-1) for codes 1 to 14. The slave in use acknowledges one cycle after it sees a request. With such a slave, the read of the next step is accepted exactly N+3 cycles after the previous write was accepted.
- R6: A step with delay code 15 performs its write. The engine then returns to idle with no delay. `done_o` is high for exactly one cycle, and `busy_o` is low in that cycle.
- R7: `trig_i` starts execution at index TRIG_IDX. When `trig_i` and `start_i` arrive in the same idle cycle, `trig_i` wins.
- R8: A `start_i` or `trig_i` that arrives while the engine is busy is ignored and sets `err_o`. `err_o` stays set until reset.
- R9: Host writes to the step memory take effect only while the engine is idle. Writes made while it is busy are dropped.
- R10: If step 255 completes without an end marker, the engine stops after that step's delay and pulses `done_o`. It does not wrap to step 0.
- R11: After reset, `busy_o`, `done_o`, `err_o` and `bus_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Host write strobe for the step memory |
| cfg_idx_i | input | 8 | Step index to write |
| cfg_word_i | input | 1 | Selects step word 0 or word 1 |
| cfg_wdata_i | input | 16 | Step word data |
| start_i | input | 1 | Start request |
| start_idx_i | input | 8 | First step for `start_i` |
| trig_i | input | 1 | Hardware trigger, starts at TRIG_IDX |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | Sticky flag for a start request made while busy |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write (1) or read (0) |
| bus_addr_o | output | 13 | Target register address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data, valid with the acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |

## Verification
The bench builds the engine with BASE_CYC=3, UNIT_CYC=2 and TRIG_IDX=200. With these values every delay code, including the largest code 14 (32766 cycles), can be run to completion and its gap measured exactly. The trigger index is placed well away from the other test steps. The default step depth of 256 is kept, so the stop after index 255 is exercised on the real last entry.

// File: rtl/regseq_pkg.sv
package regseq_pkg;
  localparam int unsigned ADDR_W = 13;
  localparam int unsigned REG_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_READ,
    ST_WRITE,
    ST_WAIT
  } state_e;

  // word 0 in the upper half, word 1 in the lower half
  typedef struct packed {
    logic [2:0]        width;
    logic [ADDR_W-1:0] addr;
    logic [3:0]        delay;
    logic [3:0]        lsb;
    logic [7:0]        data;
  } step_t;

  localparam logic [3:0] DLY_END = 4'hF;
endpackage

// File: rtl/regseq_step_mem.sv
module regseq_step_mem #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_word_i,
  input  logic [15:0]        wr_data_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output regseq_pkg::step_t  rd_step_o
);
  logic [15:0] words [2];

  for (genvar w = 0; w < 2; w++) begin : g_bank
    logic [15:0] mem [DEPTH];
    logic [15:0] rd_q;
    always_ff @(posedge clk_i) begin
      if (we_i && (wr_word_i == 1'(w))) mem[wr_idx_i] <= wr_data_i;
      if (rd_en_i) rd_q <= mem[rd_idx_i];
    end
    assign words[w] = rd_q;
  end

  assign rd_step_o = regseq_pkg::step_t'({words[0], words[1]});
endmodule

// File: rtl/regseq_delay_timer.sv
module regseq_delay_timer #(
  parameter int unsigned BASE_CYC = 41,
  parameter int unsigned UNIT_CYC = 755,
  localparam int unsigned CNT_W = $clog2(UNIT_CYC * 16383 + BASE_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [3:0] code_i,
  input  logic       run_i,
  output logic       expire_o
);
  logic [CNT_W-1:0] cnt_q, load_val;

  always_comb begin
    if (code_i == 4'd0) load_val = CNT_W'(BASE_CYC);
    else load_val = CNT_W'(UNIT_CYC) * ((CNT_W'(1) << code_i) - CNT_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (load_i) cnt_q <= load_val;
    else if (run_i && cnt_q > CNT_W'(1)) cnt_q <= cnt_q - CNT_W'(1);
  end

  // wait lasts exactly load_val cycles: expires while cnt is 1
  assign expire_o = (cnt_q <= CNT_W'(1));

  p_cnt_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && !expire_o) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/regseq_field_merge.sv
module regseq_field_merge (
  input  logic [15:0] old_i,
  input  logic [7:0]  data_i,
  input  logic [2:0]  width_i,
  input  logic [3:0]  lsb_i,
  output logic [15:0] new_o,
  output logic [15:0] mask_o
);
  logic [7:0]  low_mask;
  logic [15:0] data_sh;

  always_comb begin
    low_mask = 8'hFF >> (3'd7 - width_i);
    // 16-bit shift drops field bits above bit 15
    mask_o   = {8'h00, low_mask} << lsb_i;
    data_sh  = {8'h00, data_i & low_mask} << lsb_i;
    new_o    = (old_i & ~mask_o) | data_sh;
  end
endmodule

// File: rtl/regseq_engine.sv
module regseq_engine #(
  parameter int unsigned DEPTH    = 256,
  parameter int unsigned BASE_CYC = 41,
  parameter int unsigned UNIT_CYC = 755,
  parameter int unsigned TRIG_IDX = 0,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_we_i,
  input  logic [IDX_W-1:0]               cfg_idx_i,
  input  logic                           cfg_word_i,
  input  logic [15:0]                    cfg_wdata_i,
  input  logic                           start_i,
  input  logic [IDX_W-1:0]               start_idx_i,
  input  logic                           trig_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           err_o,
  output logic                           bus_req_o,
  output logic                           bus_we_o,
  output logic [regseq_pkg::ADDR_W-1:0]  bus_addr_o,
  output logic [15:0]                    bus_wdata_o,
  input  logic [15:0]                    bus_rdata_i,
  input  logic                           bus_ack_i
);
  import regseq_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W-1:0] TRIG_AT  = IDX_W'(TRIG_IDX);

  state_e           state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [15:0]      rd_q, rd_d;
  logic             done_q, done_d, err_q, err_d;
  logic             mem_rd_en, tmr_load, tmr_expire;
  logic [15:0]      merged, fmask;
  step_t            step;

  regseq_step_mem #(.DEPTH(DEPTH)) u_mem (
    .clk_i     (clk_i),
    .we_i      (cfg_we_i && (state_q == ST_IDLE)),
    .wr_idx_i  (cfg_idx_i),
    .wr_word_i (cfg_word_i),
    .wr_data_i (cfg_wdata_i),
    .rd_en_i   (mem_rd_en),
    .rd_idx_i  (idx_q),
    .rd_step_o (step)
  );

  regseq_delay_timer #(.BASE_CYC(BASE_CYC), .UNIT_CYC(UNIT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .code_i   (step.delay),
    .run_i    (state_q == ST_WAIT),
    .expire_o (tmr_expire)
  );

  regseq_field_merge u_merge (
    .old_i   (rd_q),
    .data_i  (step.data),
    .width_i (step.width),
    .lsb_i   (step.lsb),
    .new_o   (merged),
    .mask_o  (fmask)
  );

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    rd_d      = rd_q;
    done_d    = 1'b0;
    err_d     = err_q;
    mem_rd_en = 1'b0;
    tmr_load  = 1'b0;
    bus_req_o = 1'b0;
    bus_we_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_i) begin
          idx_d   = TRIG_AT;
          state_d = ST_FETCH;
        end else if (start_i) begin
          idx_d   = start_idx_i;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_rd_en = 1'b1;
        state_d   = ST_READ;
      end
      ST_READ: begin
        bus_req_o = 1'b1;
        if (bus_ack_i) begin
          rd_d    = bus_rdata_i;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        bus_req_o = 1'b1;
        bus_we_o  = 1'b1;
        if (bus_ack_i) begin
          if (step.delay == DLY_END) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            tmr_load = 1'b1;
            state_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_expire) begin
          if (idx_q == LAST_IDX) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            idx_d   = idx_q + IDX_W'(1);
            state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_q != ST_IDLE && (start_i || trig_i)) err_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      rd_q    <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      rd_q    <= rd_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign bus_addr_o  = step.addr;
  assign bus_wdata_o = merged;

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

  p_keep_bits_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> (((bus_wdata_o ^ rd_q) & ~fmask) == 16'h0000));

  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_busy_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (start_i || trig_i)) |=> err_o);
endmodule

// File: tb/regseq_engine_tb.sv
module regseq_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 3;
  localparam int UNIT = 2;
  localparam int TRIG = 200;
  localparam int WAIT_LIMIT = 40000;
  localparam int WD_LIMIT = 190000;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_word_i = 1'b0;
  logic [7:0]  cfg_idx_i = '0, start_idx_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        start_i = 1'b0, trig_i = 1'b0;
  logic        busy_o, done_o, err_o, bus_req_o, bus_we_o;
  logic [12:0] bus_addr_o;
  logic [15:0] bus_wdata_o, bus_rdata_i;
  logic        bus_ack_i;

  regseq_engine #(.DEPTH(256), .BASE_CYC(BASE), .UNIT_CYC(UNIT), .TRIG_IDX(TRIG)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_idx_i(cfg_idx_i),
    .cfg_word_i(cfg_word_i), .cfg_wdata_i(cfg_wdata_i), .start_i(start_i),
    .start_idx_i(start_idx_i), .trig_i(trig_i), .busy_o(busy_o), .done_o(done_o),
    .err_o(err_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  // bus slave model: ack one cycle after request
  logic [15:0] mdl [64];
  logic        pre_en = 1'b0, gap_clr = 1'b0;
  logic [5:0]  pre_addr = '0;
  logic [15:0] pre_val = '0;
  int          cyc = 0, last_wr = 0, gap_n = 0, wr_cnt = 0;
  int          gaps [8];
  logic        gap_arm = 1'b0;

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (pre_en) mdl[pre_addr] <= pre_val;
    if (gap_clr) begin
      gap_n   <= 0;
      gap_arm <= 1'b0;
    end
    if (!rst_ni) begin
      bus_ack_i   <= 1'b0;
      bus_rdata_i <= '0;
    end else if (bus_req_o && !bus_ack_i) begin
      bus_ack_i <= 1'b1;
      if (bus_we_o) begin
        mdl[bus_addr_o[5:0]] <= bus_wdata_o;
        wr_cnt  <= wr_cnt + 1;
        last_wr <= cyc;
        gap_arm <= 1'b1;
      end else begin
        bus_rdata_i <= mdl[bus_addr_o[5:0]];
        if (gap_arm && !gap_clr && gap_n < 8) begin
          gaps[gap_n] <= cyc - last_wr;
          gap_n       <= gap_n + 1;
        end
      end
    end else begin
      bus_ack_i <= 1'b0;
    end
  end

  int n_chk = 0, n_err = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] idx, input logic word, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_word_i = word; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic put_step(input logic [7:0] idx, input logic [2:0] w, input logic [12:0] a,
                          input logic [3:0] dly, input logic [3:0] lsb, input logic [7:0] d);
    host_wr(idx, 1'b0, {w, a});
    host_wr(idx, 1'b1, {dly, lsb, d});
  endtask

  task automatic set_reg(input logic [5:0] a, input logic [15:0] v);
    @(negedge clk_i);
    pre_en = 1'b1; pre_addr = a; pre_val = v;
    @(negedge clk_i);
    pre_en = 1'b0;
  endtask

  task automatic go(input logic [7:0] idx);
    @(negedge clk_i);
    start_i = 1'b1; start_idx_i = idx;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done_o && n < WAIT_LIMIT) begin
      @(negedge clk_i);
      n++;
    end
    check({tag, " done seen"}, 32'(done_o), 32'd1);
  endtask

  // {old, width, lsb, data, expected}
  localparam logic [46:0] VEC [7] = '{
    {16'h0000, 3'd7, 4'd0,  8'hA5, 16'h00A5},
    {16'hFFFF, 3'd0, 4'd4,  8'h00, 16'hFFEF},
    {16'h1234, 3'd3, 4'd8,  8'hFB, 16'h1B34},
    {16'h0000, 3'd7, 4'd12, 8'hFF, 16'hF000},
    {16'hAAAA, 3'd2, 4'd13, 8'h02, 16'h4AAA},
    {16'h5555, 3'd4, 4'd0,  8'hE0, 16'h5540},
    {16'h0F0F, 3'd1, 4'd15, 8'h03, 16'h8F0F}
  };

  always @(posedge clk_i) begin
    if (cyc == WD_LIMIT) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 busy", 32'(busy_o), 0);
    check("R11 done", 32'(done_o), 0);
    check("R11 err", 32'(err_o), 0);
    check("R11 req", 32'(bus_req_o), 0);
    rst_ni = 1'b1;

    // R1 R2 R3 R4: field merge vectors, one end-marked step each
    for (int v = 0; v < 7; v++) begin
      logic [46:0] e;
      e = VEC[v];
      set_reg(6'(v), e[46:31]);
      put_step(8'(20 + v), e[30:28], 13'h1A40 + 13'(v), 4'hF, e[27:24], e[23:16]);
      go(8'(20 + v));
      wait_done("R4 vec");
      @(negedge clk_i);
      check($sformatf("R2 R3 R4 vec%0d result", v), 32'(mdl[v]), 32'(e[15:0]));
    end

    // R5 delays: codes 0, 3, 1, 14 then end
    put_step(8'd40, 3'd7, 13'h0010, 4'd0,  4'd0, 8'h01);
    put_step(8'd41, 3'd7, 13'h0011, 4'd3,  4'd0, 8'h02);
    put_step(8'd42, 3'd7, 13'h0012, 4'd1,  4'd0, 8'h03);
    put_step(8'd43, 3'd7, 13'h0013, 4'd14, 4'd0, 8'h04);
    put_step(8'd44, 3'd7, 13'h0014, 4'hF,  4'd0, 8'h05);
    @(negedge clk_i); gap_clr = 1'b1;
    @(negedge clk_i); gap_clr = 1'b0;
    go(8'd40);
    wait_done("R5 seq");
    // R6: single-cycle pulse, idle
    check("R6 busy low at done", 32'(busy_o), 0);
    @(negedge clk_i);
    check("R6 done one cycle", 32'(done_o), 0);
    check("R5 gap count", 32'(gap_n), 4);
    check("R5 code0 gap", 32'(gaps[0]), 32'(BASE + 3));
    check("R5 code3 gap", 32'(gaps[1]), 32'(UNIT * 7 + 3));
    check("R5 code1 gap", 32'(gaps[2]), 32'(UNIT + 3));
    check("R5 code14 gap", 32'(gaps[3]), 32'(UNIT * 16383 + 3));
    check("R6 end step written", 32'(mdl[20]), 32'h0005);

    // R8 R9: start and host write while busy
    set_reg(6'd5, 16'h0000);
    set_reg(6'd6, 16'h0000);
    put_step(8'd60, 3'd7, 13'h0020, 4'd2, 4'd0, 8'h10);
    put_step(8'd61, 3'd7, 13'h0005, 4'hF, 4'd0, 8'h3C);
    put_step(8'd70, 3'd7, 13'h0006, 4'hF, 4'd0, 8'h77);
    go(8'd60);
    repeat (3) @(negedge clk_i);
    host_wr(8'd61, 1'b1, 16'hF0C3);
    go(8'd70);
    wait_done("R8 seq");
    @(negedge clk_i);
    check("R8 err set", 32'(err_o), 1);
    check("R8 busy start ignored", 32'(mdl[6]), 0);
    check("R9 busy host write dropped", 32'(mdl[5]), 32'h003C);
    go(8'd70);
    wait_done("R8 idle start");
    @(negedge clk_i);
    check("R8 idle start runs", 32'(mdl[6]), 32'h0077);
    check("R8 err sticky", 32'(err_o), 1);

    // R7 trigger wins over start
    set_reg(6'd10, 16'h0000);
    set_reg(6'd11, 16'h0000);
    put_step(8'(TRIG), 3'd7, 13'h000A, 4'hF, 4'd0, 8'h5A);
    put_step(8'd90, 3'd7, 13'h000B, 4'hF, 4'd0, 8'h66);
    @(negedge clk_i);
    trig_i = 1'b1; start_i = 1'b1; start_idx_i = 8'd90;
    @(negedge clk_i);
    trig_i = 1'b0; start_i = 1'b0;
    wait_done("R7 trig");
    @(negedge clk_i);
    check("R7 trig step run", 32'(mdl[10]), 32'h005A);
    check("R7 start step skipped", 32'(mdl[11]), 0);

    // R10 stop after 255
    set_reg(6'd8, 16'h0000);
    set_reg(6'd9, 16'h0000);
    put_step(8'd254, 3'd7, 13'h0007, 4'd0, 4'd0, 8'h11);
    put_step(8'd255, 3'd7, 13'h0008, 4'd0, 4'd0, 8'h22);
    put_step(8'd0,   3'd7, 13'h0009, 4'hF, 4'd0, 8'h33);
    begin
      int w0;
      w0 = wr_cnt;
      go(8'd254);
      wait_done("R10 run");
      @(negedge clk_i);
      check("R10 write count", 32'(wr_cnt - w0), 2);
    end
    check("R10 step255 written", 32'(mdl[8]), 32'h0022);
    check("R10 no wrap", 32'(mdl[9]), 0);
    check("R10 idle", 32'(busy_o), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule